// File: doc/BRIEF.md
# Reconfigurable 8-Point / Dual 4-Point Integer DCT

This block is a one-dimensional integer DCT engine with eight signed input lanes. A mode input chooses, for each vector, between two behaviours. The first is one 8-point transform over all eight lanes. The second is two independent 4-point transforms: one over lanes 0..3 and one over lanes 4..7. Both modes use the standard integer kernels with coefficient magnitudes 64, 83, 36, 89, 75, 50 and 18. A new vector can enter every cycle, and eight coefficients leave every cycle whatever the mode.

The datapath is built as follows. An input butterfly forms sums a(i) = x(i) + x(7-i) and differences b(i) = x(i) - x(7-i). A 4-point core produces the even half. In 8-point mode the core is fed the sums. In dual mode it is fed raw lanes 0..3. Four position-specific shift-add units and an add/subtract tree produce the odd half of the 8-point result, or the second 4-point result. Each shift-add unit picks between two coefficient sets with multiplexers only. The operation of each tree cell is switched by the mode.

The result is registered once, so it appears one cycle after the vector is accepted. The mode travels with the vector, so consecutive vectors may use different modes.

Top module: `dctReconfig8`

## Requirements
- R1: With dualMode = 0, output lane k equals the dot product of row k of the 8-point integer DCT kernel with input lanes 0..7. Row 0 is all 64. Row 1 is 89, 75, 50, 18, -18, -50, -75, -89. Row 2 is 83, 36, -36, -83, -83, -36, 36, 83. Row 3 is 75, -18, -89, -50, 50, 89, 18, -75. Row 4 is 64, -64, -64, 64, 64, -64, -64, 64. Row 5 is 50, -89, 18, 75, -75, -18, 89, -50. Row 6 is 36, -83, 83, -36, -36, 83, -83, 36. Row 7 is 18, -50, 75, -89, 89, -75, 50, -18.
- R2: With dualMode = 1, output lanes 0..3 carry the 4-point transform of input lanes 0..3 in coefficient order, and output lanes 4..7 carry the 4-point transform of input lanes 4..7. The 4-point rows are 64, 64, 64, 64 / 83, 36, -36, -83 / 64, -64, -64, 64 / 36, -83, 83, -36.
- R3: A vector accepted with inValid high at a clock edge appears on coefOut, with outValid high, after exactly that edge. outValid is low after any edge where inValid was low.
- R4: While inValid is low, coefOut holds its previous value whatever sampleIn and dualMode do.
- R5: dualMode is sampled together with each vector, so vectors of alternating mode presented on consecutive cycles each produce the result of their own mode.
- R6: While rstN is low, outValid is 0 and every coefOut lane is 0.
- R7: Full-scale signed inputs (all lanes at the most positive or most negative value, or alternating extremes) produce exact results with no wrap. Each output lane is DW+10 bits wide, two's complement.
- R8: In dual mode, lanes 0..3 of the result depend only on input lanes 0..3, whatever values lanes 4..7 hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Vector on sampleIn is accepted at this edge |
| dualMode | input | 1 | 0: one 8-point transform; 1: two 4-point transforms |
| sampleIn | input | 8 x DW | Eight signed two's-complement input lanes, lane 0 in the low bits |
| coefOut | output | 8 x (DW+10) | Eight signed output coefficients, lane 0 in the low bits |
| outValid | output | 1 | coefOut holds the result of the vector accepted at the previous edge |

## Verification
The hardest case to reach is a mode change between two vectors that are in flight together. The mux row and the tree signs must then follow the new vector while the previous result is still leaving the register. The stimulus table is streamed with inValid held high on every cycle, and the mode alternates between entries. Each result is checked in the cycle a later vector is being accepted.

For the independence of the two 4-point halves, dual vectors that share lanes 0..3 but differ in lanes 4..7 are sent back to back. Full-scale entries then exercise the widest sums and differences in both modes.

// File: rtl/dct_pkg.sv
package dct_pkg;
  localparam int LANES  = 8;
  localparam int HALF   = LANES / 2;
  localparam int GROWTH = 10;

  typedef enum logic [2:0] {K18, K36, K50, K64, K75, K83, K89} coefSel_e;

  typedef struct packed {
    logic load;
    logic dual;
  } dctStrobe_t;

  // Tree sign masks, bit (row*4 + unit) set when that product is subtracted.
  localparam logic [15:0] NEG_SINGLE = 16'hA2E0;
  localparam logic [15:0] NEG_DUAL   = 16'hA6C0;

  function automatic coefSel_e pickCoef(int pos, int row, logic dual);
    coefSel_e t8 [4];
    coefSel_e t4 [4];
    case (pos)
      0: begin
        t8 = '{K89, K75, K50, K18};
        t4 = '{K64, K83, K64, K36};
      end
      1: begin
        t8 = '{K75, K18, K89, K50};
        t4 = '{K64, K36, K64, K83};
      end
      2: begin
        t8 = '{K50, K89, K18, K75};
        t4 = '{K64, K36, K64, K83};
      end
      default: begin
        t8 = '{K18, K50, K75, K89};
        t4 = '{K64, K83, K64, K36};
      end
    endcase
    return dual ? t4[row] : t8[row];
  endfunction
endpackage

// File: rtl/dctCtrl.sv
module dctCtrl
  import dct_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       dualMode,
  output dctStrobe_t strobe,
  output logic       outValid
);
  always_comb begin
    strobe.load = inValid;
    strobe.dual = dualMode;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end
endmodule

// File: rtl/dctInner4.sv
module dctInner4
  import dct_pkg::*;
#(
  parameter int IW = 26
) (
  input  logic signed [IW-1:0] u [HALF],
  output logic signed [IW-1:0] c [HALF]
);
  logic signed [IW-1:0] e0, e1, o0, o1;
  logic signed [IW-1:0] o0x9, o1x9;

  always_comb begin
    e0   = u[0] + u[3];
    e1   = u[1] + u[2];
    o0   = u[0] - u[3];
    o1   = u[1] - u[2];
    o0x9 = (o0 <<< 3) + o0;
    o1x9 = (o1 <<< 3) + o1;
    c[0] = (e0 + e1) <<< 6;
    c[2] = (e0 - e1) <<< 6;
    // 83v = 64v + 2*9v + v ; 36v = 4*9v
    c[1] = ((o0 <<< 6) + (o0x9 <<< 1) + o0) + (o1x9 <<< 2);
    c[3] = (o0x9 <<< 2) - ((o1 <<< 6) + (o1x9 <<< 1) + o1);
  end
endmodule

// File: rtl/dctCfgUnit.sv
module dctCfgUnit
  import dct_pkg::*;
#(
  parameter int POS = 0,
  parameter int IW  = 26
) (
  input  logic                 dual,
  input  logic signed [IW-1:0] operand,
  output logic signed [IW-1:0] prod [HALF]
);
  logic signed [IW-1:0] m9;
  logic signed [IW-1:0] mult [7];

  always_comb begin
    m9 = (operand <<< 3) + operand;
    mult[int'(K64)] = operand <<< 6;
    mult[int'(K18)] = m9 <<< 1;
    mult[int'(K36)] = m9 <<< 2;
    mult[int'(K50)] = (operand <<< 5) + (m9 <<< 1);
    mult[int'(K75)] = (operand <<< 6) + m9 + (operand <<< 1);
    mult[int'(K83)] = (operand <<< 6) + (m9 <<< 1) + operand;
    mult[int'(K89)] = (operand <<< 6) + (operand <<< 4) + m9;
  end

  for (genvar k = 0; k < HALF; k++) begin : gRow
    localparam coefSel_e SEL8 = pickCoef(POS, k, 1'b0);
    localparam coefSel_e SEL4 = pickCoef(POS, k, 1'b1);
    assign prod[k] = dual ? mult[int'(SEL4)] : mult[int'(SEL8)];
  end
endmodule

// File: rtl/dctDatapath.sv
module dctDatapath
  import dct_pkg::*;
#(
  parameter int DW = 16,
  parameter int OW = DW + GROWTH
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  dctStrobe_t                      strobe,
  input  logic [LANES-1:0][DW-1:0]        sampleIn,
  output logic [LANES-1:0][OW-1:0]        coefOut
);
  logic signed [OW-1:0] x       [LANES];
  logic signed [OW-1:0] innerIn [HALF];
  logic signed [OW-1:0] cfgIn   [HALF];
  logic signed [OW-1:0] even    [HALF];
  logic signed [OW-1:0] odd     [HALF];
  logic signed [OW-1:0] prod    [HALF][HALF];
  logic signed [OW-1:0] nxt     [LANES];

  // Input butterfly and mux row
  always_comb begin
    for (int i = 0; i < LANES; i++) x[i] = OW'($signed(sampleIn[i]));
    for (int i = 0; i < HALF; i++) begin
      innerIn[i] = strobe.dual ? x[i]        : x[i] + x[LANES-1-i];
      cfgIn[i]   = strobe.dual ? x[HALF + i] : x[i] - x[LANES-1-i];
    end
  end

  dctInner4 #(.IW(OW)) uInner (.u(innerIn), .c(even));

  for (genvar g = 0; g < HALF; g++) begin : gCfg
    dctCfgUnit #(.POS(g), .IW(OW)) uCfg (
      .dual(strobe.dual), .operand(cfgIn[g]), .prod(prod[g])
    );
  end

  // Sign-configurable add/subtract tree
  always_comb begin
    logic [15:0] negMask;
    logic signed [OW-1:0] s01, s23;
    negMask = strobe.dual ? NEG_DUAL : NEG_SINGLE;
    for (int k = 0; k < HALF; k++) begin
      s01 = negMask[k*4+1] ? prod[0][k] - prod[1][k] : prod[0][k] + prod[1][k];
      s23 = (negMask[k*4+2] ^ negMask[k*4+3]) ? prod[2][k] - prod[3][k]
                                               : prod[2][k] + prod[3][k];
      odd[k] = negMask[k*4+2] ? s01 - s23 : s01 + s23;
    end
  end

  // Lane routing
  always_comb begin
    if (strobe.dual) begin
      for (int j = 0; j < HALF; j++) begin
        nxt[j]        = even[j];
        nxt[HALF + j] = odd[j];
      end
    end else begin
      for (int j = 0; j < HALF; j++) begin
        nxt[2*j]     = even[j];
        nxt[2*j + 1] = odd[j];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      coefOut <= '0;
    end else if (strobe.load) begin
      for (int j = 0; j < LANES; j++) coefOut[j] <= nxt[j];
    end
  end
endmodule

// File: rtl/dctReconfig8.sv
module dctReconfig8
  import dct_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               inValid,
  input  logic                               dualMode,
  input  logic [LANES-1:0][DW-1:0]           sampleIn,
  output logic [LANES-1:0][DW+GROWTH-1:0]    coefOut,
  output logic                               outValid
);
  dctStrobe_t strobe;

  dctCtrl uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .dualMode(dualMode),
    .strobe(strobe), .outValid(outValid)
  );

  dctDatapath #(.DW(DW), .OW(DW + GROWTH)) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .sampleIn(sampleIn), .coefOut(coefOut)
  );
endmodule

// File: rtl/dctReconfig8Chk.sv
module dctReconfig8Chk
  import dct_pkg::*;
#(
  parameter int DW = 16
) (
  input logic                               clk,
  input logic                               rstN,
  input logic                               inValid,
  input logic                               dualMode,
  input logic [LANES-1:0][DW-1:0]           sampleIn,
  input logic [LANES-1:0][DW+GROWTH-1:0]    coefOut,
  input logic                               outValid
);
  localparam int OW = DW + GROWTH;
  logic signed [OW-1:0] sumAll, sumLo, sumHi;

  always_comb begin
    sumLo = '0;
    sumHi = '0;
    for (int i = 0; i < HALF; i++) begin
      sumLo = sumLo + OW'($signed(sampleIn[i]));
      sumHi = sumHi + OW'($signed(sampleIn[HALF + i]));
    end
    sumAll = sumLo + sumHi;
  end

  // R1: DC term of the 8-point transform
  a_r1_dc_single: assert property (@(posedge clk) disable iff (!rstN)
    inValid && !dualMode |=> coefOut[0] == $past(sumAll <<< 6));

  // R2: DC terms of both 4-point transforms
  a_r2_dc_dual: assert property (@(posedge clk) disable iff (!rstN)
    inValid && dualMode |=> coefOut[0] == $past(sumLo <<< 6)
                         && coefOut[HALF] == $past(sumHi <<< 6));

  a_r3_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  a_r3_valid_drops: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  a_r4_hold: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(coefOut));

  a_r6_reset_clear: assert property (@(posedge clk)
    !rstN |=> !outValid && coefOut == '0);
endmodule

bind dctReconfig8 dctReconfig8Chk #(.DW(DW)) uChk (.*);

// File: tb/tb_dctReconfig8.sv
module tb_dctReconfig8;
  localparam int PERIOD = 10;
  localparam int DW     = 16;
  localparam int OW     = DW + 10;
  localparam int N      = 12;

  localparam int K8 [64] = '{
    64,  64,  64,  64,  64,  64,  64,  64,
    89,  75,  50,  18, -18, -50, -75, -89,
    83,  36, -36, -83, -83, -36,  36,  83,
    75, -18, -89, -50,  50,  89,  18, -75,
    64, -64, -64,  64,  64, -64, -64,  64,
    50, -89,  18,  75, -75, -18,  89, -50,
    36, -83,  83, -36, -36,  83, -83,  36,
    18, -50,  75, -89,  89, -75,  50, -18};
  localparam int K4 [16] = '{
    64,  64,  64,  64,
    83,  36, -36, -83,
    64, -64, -64,  64,
    36, -83,  83, -36};

  localparam int STIM [N][8] = '{
    '{1, 0, 0, 0, 0, 0, 0, 0},
    '{1, 0, 0, 0, 0, 0, 0, 0},
    '{1, 2, 3, 4, 5, 6, 7, 8},
    '{1, 2, 3, 4, 5, 6, 7, 8},
    '{100, -200, 300, -400, 500, -600, 700, -800},
    '{-7, 13, 250, -1000, 42, -3, 999, -512},
    '{5, 6, 7, 8, -1, 2, -3, 4},
    '{5, 6, 7, 8, 300, -300, 1000, -30000},
    '{32767, 32767, 32767, 32767, 32767, 32767, 32767, 32767},
    '{-32768, 32767, -32768, 32767, 32767, -32768, 32767, -32768},
    '{-32768, -32768, -32768, -32768, -32768, -32768, -32768, -32768},
    '{0, 0, 0, 0, 0, 0, 0, -1}};
  localparam bit DUALV [N] = '{0, 1, 0, 1, 0, 1, 1, 1, 0, 0, 1, 0};

  logic clk = 1'b0;
  logic rstN, inValid, dualMode;
  logic [7:0][DW-1:0] sampleIn;
  logic [7:0][OW-1:0] coefOut;
  logic outValid;

  int checkCount = 0;
  int failCount  = 0;
  int held [8];

  always #(PERIOD/2) clk = ~clk;

  dctReconfig8 #(.DW(DW)) dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .dualMode(dualMode),
    .sampleIn(sampleIn), .coefOut(coefOut), .outValid(outValid)
  );

  function automatic int refCoef(bit dual, int x[8], int k);
    int acc = 0;
    if (!dual) begin
      for (int n = 0; n < 8; n++) acc += K8[k*8 + n] * x[n];
    end else begin
      int base = (k < 4) ? 0 : 4;
      int row  = k % 4;
      for (int n = 0; n < 4; n++) acc += K4[row*4 + n] * x[base + n];
    end
    return acc;
  endfunction

  function automatic string tagFor(int idx);
    if (idx == 6 || idx == 7) return "R8";
    if (idx >= 8 && idx <= 10) return "R7";
    return DUALV[idx] ? "R2" : "R1";
  endfunction

  task automatic drive(bit dual, int x[8]);
    inValid  = 1'b1;
    dualMode = dual;
    for (int i = 0; i < 8; i++) sampleIn[i] = DW'(x[i]);
  endtask

  task automatic checkOut(string tag, bit dual, int x[8]);
    bit bad = 0;
    checkCount++;
    if (outValid !== 1'b1) begin
      $display("FAIL %s (R3) outValid actual %b expected 1", tag, outValid);
      bad = 1;
    end
    for (int j = 0; j < 8; j++) begin
      int exp = refCoef(dual, x, j);
      int act = int'($signed(coefOut[j]));
      if (act != exp) begin
        $display("FAIL %s lane %0d actual %0d expected %0d", tag, j, act, exp);
        bad = 1;
      end
    end
    if (bad) failCount++;
  endtask

  task automatic finish();
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  endtask

  initial begin
    #(PERIOD * 50000);
    checkCount++;
    failCount++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    rstN = 1'b0;
    inValid = 1'b0;
    dualMode = 1'b0;
    sampleIn = '0;
    repeat (3) @(negedge clk);
    // R6: reset state
    checkCount++;
    if (outValid !== 1'b0 || coefOut !== '0) begin
      failCount++;
      $display("FAIL R6 outValid %b coef %h expected 0 and 0", outValid, coefOut);
    end
    rstN = 1'b1;
    @(negedge clk);

    // Streamed table, mode alternating back to back (R5)
    for (int idx = 0; idx < N; idx++) begin
      @(negedge clk);
      if (idx > 0)
        checkOut($sformatf("%s/R5 vec %0d", tagFor(idx-1), idx-1), DUALV[idx-1], STIM[idx-1]);
      drive(DUALV[idx], STIM[idx]);
    end
    @(negedge clk);
    checkOut($sformatf("%s/R5 vec %0d", tagFor(N-1), N-1), DUALV[N-1], STIM[N-1]);
    for (int j = 0; j < 8; j++) held[j] = int'($signed(coefOut[j]));

    // R4 and R3: idle cycles with changing inputs
    inValid = 1'b0;
    for (int c = 0; c < 3; c++) begin
      dualMode = c[0];
      for (int i = 0; i < 8; i++) sampleIn[i] = DW'(1000 * (c + 1) + i);
      @(negedge clk);
      checkCount++;
      begin
        bit bad = 0;
        if (outValid !== 1'b0) begin
          $display("FAIL R3 outValid actual %b expected 0", outValid);
          bad = 1;
        end
        for (int j = 0; j < 8; j++)
          if (int'($signed(coefOut[j])) != held[j]) begin
            $display("FAIL R4 lane %0d actual %0d expected %0d", j,
                     int'($signed(coefOut[j])), held[j]);
            bad = 1;
          end
        if (bad) failCount++;
      end
    end

    // R8: isolated dual vector after idle, then one with different upper half
    begin
      int xa [8] = '{-100, 200, -300, 400, 1, 1, 1, 1};
      int xb [8] = '{-100, 200, -300, 400, -32768, 32767, 0, 12345};
      drive(1'b1, xa);
      @(negedge clk);
      checkOut("R8 isolated", 1'b1, xa);
      drive(1'b1, xb);
      @(negedge clk);
      checkOut("R8 upper changed", 1'b1, xb);
      inValid = 1'b0;
      // R1: single-mode vector after a dual one
      drive(1'b0, xb);
      @(negedge clk);
      checkOut("R1 after dual", 1'b0, xb);
      inValid = 1'b0;
    end

    // R6: reset mid-run clears the outputs
    rstN = 1'b0;
    @(negedge clk);
    checkCount++;
    if (outValid !== 1'b0 || coefOut !== '0) begin
      failCount++;
      $display("FAIL R6 after run outValid %b coef %h expected 0 and 0", outValid, coefOut);
    end
    rstN = 1'b1;
    @(negedge clk);
    finish();
  end
endmodule